// File: doc/BRIEF.md
# Transmit Minimum-Length Padder and Frame Check Sequence Generator

This block is a streaming stage on the transmit side of an Ethernet MAC. Frames arrive as a byte stream. Each byte carries a first-byte marker and a last-byte marker, and the stream uses a valid/ready handshake. Data bytes pass straight through with no added latency. When padding is enabled and a frame holds fewer than 60 data bytes, the block inserts zero bytes after the payload. It then appends a CRC-32 frame check sequence computed over every byte it emitted, pad included, so that the frame reaches the 64-byte minimum.

A frame that needs no padding gets a check sequence only when two conditions hold: the frame asked for one on its first byte, and the global disable is clear. A frame that was padded always gets a valid check sequence, whatever those two controls say. While pad or check bytes are being produced the upstream side is held off. The next frame is accepted only after the final check byte has been taken downstream.

Top module: `tx_pad_fcs`

## Requirements
- R1: In pass-through, a byte accepted on the input appears on the output in the same cycle, unchanged, with the same first-byte marker, and inReady equals outReady.
- R2: With padEn=1, a frame of N<60 data bytes is followed by 60-N bytes of value 0x00, so the output frame including its check sequence is exactly 64 bytes.
- R3: The check sequence is the reflected CRC-32 (polynomial 0x04C11DB7, bit-reversed form 0xEDB88320), initial value 0xFFFFFFFF, result inverted. It covers every data and pad byte of the frame, is sent least significant byte first as the last four bytes, and only its final byte carries outEof (for the nine ASCII bytes "123456789" the bytes are 26 39 F4 CB).
- R4: A padded frame always ends with a valid check sequence, even when fcsOff=1 and the frame's inAddFcs was 0.
- R5: With padEn=0, no frame is padded, whatever its length.
- R6: A frame of 60 or more data bytes is never padded; with inAddFcs=1 and fcsOff=0 a 60-byte frame leaves as 64 bytes.
- R7: An unpadded frame gets a check sequence only when inAddFcs (sampled with the first byte) is 1 and fcsOff is 0; otherwise it leaves unchanged, with outEof on its last data byte.
- R8: From the cycle after the last data byte of a frame that needs pad or check bytes is accepted, inReady stays low until the last check byte has been accepted downstream.
- R9: While outValid is high and outReady is low, outValid stays high and outData and outEof hold their values in the next cycle.
- R10: After reset the block is in pass-through: with no valid input, outValid is low and inReady equals outReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| padEn | input | 1 | Enables short-frame padding; sampled with the last data byte |
| fcsOff | input | 1 | Global disable of the check sequence for unpadded frames |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts the input byte |
| inData | input | 8 | Input byte |
| inSof | input | 1 | Marks the first byte of a frame |
| inEof | input | 1 | Marks the last data byte of a frame |
| inAddFcs | input | 1 | Per-frame check-sequence request, sampled with the first byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the output byte |
| outData | output | 8 | Output byte |
| outSof | output | 1 | Marks the first output byte of a frame |
| outEof | output | 1 | Marks the last output byte of a frame |

## Verification
A wrong byte count would show as a frame whose padded length is not 64. A wrong check-sequence register would show as the last four bytes of the very next frame that gets a check sequence. Either error appears within one frame. A wrong state decision shows at once: a missing or extra tail, or outEof on the wrong byte. It also shows as inReady being high while the tail is still going out, which lets a probe byte in on the first cycle it should be blocked. Stall errors show in the cycle after a refused output byte, as a dropped valid or a changed byte.

// File: rtl/txpad_pkg.sv
package txpad_pkg;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_PAD  = 2'd1,
    SRC_FCS  = 2'd2
  } srcSel_e;

  typedef struct packed {
    srcSel_e    src;
    logic       crcRestart;
    logic       crcStep;
    logic [1:0] fcsIdx;
  } padCtl_t;

  // one byte of the reflected CRC-32, least significant bit first
  function automatic logic [31:0] crcAddByte(logic [31:0] crcIn, logic [7:0] b);
    logic [31:0] r;
    r = crcIn ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txpad_ctrl.sv
module txpad_ctrl
  import txpad_pkg::*;
#(
  parameter int MIN_DATA = 60
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    padEn,
  input  logic    fcsOff,
  input  logic    inValid,
  input  logic    inSof,
  input  logic    inEof,
  input  logic    inAddFcs,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output logic    outSof,
  output logic    outEof,
  output padCtl_t ctl
);

  localparam int CNT_W = $clog2(MIN_DATA + 2);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_DATA);

  typedef enum logic [1:0] {ST_PASS, ST_PAD, ST_FCS} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             addFcsQ;
  logic [1:0]       fcsIdx;

  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] lenNow;
  logic             frameFcs;
  logic             needPad;
  logic             needFcs;
  logic             outFire;

  always_comb begin
    baseCnt  = inSof ? '0 : cnt;
    lenNow   = baseCnt + 1'b1;
    frameFcs = inSof ? inAddFcs : addFcsQ;
    needPad  = padEn && (lenNow < MIN_CNT);
    needFcs  = needPad || (frameFcs && !fcsOff);
    outFire  = outValid && outReady;
  end

  always_comb begin
    ctl            = '0;
    ctl.fcsIdx     = fcsIdx;
    inReady        = 1'b0;
    outValid       = 1'b0;
    outSof         = 1'b0;
    outEof         = 1'b0;
    unique case (state)
      ST_PASS: begin
        inReady        = outReady;
        outValid       = inValid;
        outSof         = inSof;
        outEof         = inEof && !needFcs;
        ctl.src        = SRC_DATA;
        ctl.crcRestart = inSof;
        ctl.crcStep    = inValid && outReady;
      end
      ST_PAD: begin
        outValid       = 1'b1;
        ctl.src        = SRC_PAD;
        ctl.crcStep    = outReady;
      end
      default: begin
        outValid       = 1'b1;
        outEof         = (fcsIdx == 2'd3);
        ctl.src        = SRC_FCS;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_PASS;
      cnt     <= '0;
      addFcsQ <= 1'b0;
      fcsIdx  <= '0;
    end else if (outFire) begin
      unique case (state)
        ST_PASS: begin
          cnt     <= (lenNow > MIN_CNT) ? MIN_CNT : lenNow;
          addFcsQ <= frameFcs;
          fcsIdx  <= '0;
          if (inEof) begin
            if (needPad)      state <= ST_PAD;
            else if (needFcs) state <= ST_FCS;
          end
        end
        ST_PAD: begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 >= MIN_CNT) state <= ST_FCS;
        end
        default: begin
          fcsIdx <= fcsIdx + 1'b1;
          if (fcsIdx == 2'd3) state <= ST_PASS;
        end
      endcase
    end
  end

endmodule

// File: rtl/txpad_dpath.sv
module txpad_dpath
  import txpad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  padCtl_t    ctl,
  output logic [7:0] outData
);

  localparam int FCS_BYTES = 4;

  logic [31:0] crcQ;
  logic [31:0] crcBase;
  logic [31:0] fcsWord;
  logic [7:0]  emitByte;
  logic [7:0]  fcsBytes [FCS_BYTES];

  assign fcsWord = ~crcQ;

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_fcsLane
    assign fcsBytes[g] = fcsWord[8*g +: 8];
  end

  always_comb begin
    unique case (ctl.src)
      SRC_DATA: emitByte = inData;
      SRC_PAD:  emitByte = 8'h00;
      default:  emitByte = fcsBytes[ctl.fcsIdx];
    endcase
    crcBase = ctl.crcRestart ? 32'hFFFF_FFFF : crcQ;
  end

  assign outData = emitByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ <= 32'hFFFF_FFFF;
    end else if (ctl.crcStep) begin
      crcQ <= crcAddByte(crcBase, emitByte);
    end
  end

endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import txpad_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       padEn,
  input  logic       fcsOff,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       inAddFcs,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       outSof,
  output logic       outEof
);

  localparam int MIN_DATA = MIN_FRAME - 4;

  padCtl_t ctl;

  txpad_ctrl #(.MIN_DATA(MIN_DATA)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .padEn    (padEn),
    .fcsOff   (fcsOff),
    .inValid  (inValid),
    .inSof    (inSof),
    .inEof    (inEof),
    .inAddFcs (inAddFcs),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .outSof   (outSof),
    .outEof   (outEof),
    .ctl      (ctl)
  );

  txpad_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .ctl     (ctl),
    .outData (outData)
  );

endmodule

// File: rtl/txpad_chk.sv
module txpad_chk #(
  parameter int MIN_FRAME = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       padEn,
  input logic       inValid,
  input logic       inReady,
  input logic [7:0] inData,
  input logic       inSof,
  input logic       inEof,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outSof,
  input logic       outEof
);

  localparam int MIN_DATA = MIN_FRAME - 4;

  logic [15:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt <= '0;
    end else if (outValid && outReady) begin
      if (outEof)                outCnt <= '0;
      else if (outCnt != 16'hFFFF) outCnt <= outCnt + 16'd1;
    end
  end

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outValid && outData == inData && outSof == inSof));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outEof)));

  // R8
  tail_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inEof && !outEof) |=> !inReady);

  // R2
  pad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEof && padEn) |-> (outCnt >= 16'(MIN_DATA - 1)));

endmodule

bind tx_pad_fcs txpad_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .padEn    (padEn),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .inSof    (inSof),
  .inEof    (inEof),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outSof   (outSof),
  .outEof   (outEof)
);

// File: tb/tx_pad_fcs_tb.sv
`timescale 1ns/1ps
module tx_pad_fcs_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       padEn = 1'b0, fcsOff = 1'b0;
  logic       inValid = 1'b0, inSof = 1'b0, inEof = 1'b0, inAddFcs = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       outReady = 1'b1;
  logic       inReady, outValid, outSof, outEof;
  logic [7:0] outData;

  int checks = 0, failures = 0;
  int rxDone = 0;
  int tailReq = 0, tailAck = 0;
  int r8Viol = 0, r9Viol = 0;
  bit randReady = 0;
  bit gapsOn = 0;
  logic [7:0] rxData[$];
  bit         rxSof[$];

  always #2 clk = ~clk;

  tx_pad_fcs u_dut (
    .clk(clk), .rstN(rstN), .padEn(padEn), .fcsOff(fcsOff),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSof(inSof),
    .inEof(inEof), .inAddFcs(inAddFcs), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outSof(outSof), .outEof(outEof)
  );

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // MSB-first CRC on bit-reversed bytes, then reflected and inverted
  function automatic logic [31:0] refCrc(ref logic [7:0] q[$]);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      b = rev8(q[i]);
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ b[7-k];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return ~rev32(c);
  endfunction

  function automatic void buildExp(ref logic [7:0] d[$], ref logic [7:0] e[$],
                                   input bit pe, input bit fo, input bit af);
    logic [31:0] c;
    bit padded;
    e = d;
    padded = pe && (d.size() < 60);
    while (padded && e.size() < 60) e.push_back(8'h00);
    if (padded || (af && !fo)) begin
      c = refCrc(e);
      for (int k = 0; k < 4; k++) e.push_back(c[8*k +: 8]);
    end
  endfunction

  // output driver
  initial begin
    forever begin
      @(posedge clk); #1;
      outReady = randReady ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor, sampling on the falling edge
  logic       prevStall = 1'b0;
  logic [7:0] prevData  = 8'h00;
  logic       prevEof   = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (prevStall && !(outValid && outData == prevData && outEof == prevEof)) r9Viol++;
        if (tailReq != tailAck && inReady) r8Viol++;
        if (outValid && outReady) begin
          rxData.push_back(outData);
          rxSof.push_back(outSof);
          if (outEof) begin
            rxDone++;
            if (tailReq != tailAck) tailAck++;
          end
        end
        prevStall = outValid && !outReady;
        prevData  = outData;
        prevEof   = outEof;
      end
    end
  end

  task automatic sendFrame(ref logic [7:0] d[$], input bit af, input bit probe);
    bit acc;
    for (int i = 0; i < d.size(); i++) begin
      inValid = 1'b1; inData = d[i]; inSof = (i == 0);
      inEof = (i == d.size() - 1); inAddFcs = af;
      do begin
        @(negedge clk); acc = inReady;
        @(posedge clk); #1;
      end while (!acc);
      inValid = 1'b0;
      if (gapsOn && ($urandom % 4 == 0)) begin @(posedge clk); #1; end
    end
    if (probe) begin
      inValid = 1'b1; inSof = 1'b1; inEof = 1'b0; inData = 8'hA5;
      tailReq++;
      while (tailReq != tailAck) begin @(posedge clk); #1; end
      inValid = 1'b0; inSof = 1'b0;
    end
  endtask

  task automatic runFrame(string tag, ref logic [7:0] d[$], input bit pe,
                          input bit fo, input bit af, ref logic [7:0] got[$]);
    logic [7:0] e[$];
    int target;
    bit bad;
    string why;
    buildExp(d, e, pe, fo, af);
    padEn = pe; fcsOff = fo;
    target = rxDone + 1;
    sendFrame(d, af, e.size() > d.size());
    while (rxDone < target) begin @(posedge clk); #1; end
    checks++;
    bad = 0; why = "";
    if (rxData.size() != e.size()) begin
      bad = 1; why = $sformatf("length got %0d exp %0d", rxData.size(), e.size());
    end else begin
      foreach (e[i]) begin
        if (!bad && (rxData[i] !== e[i] || rxSof[i] !== (i == 0))) begin
          bad = 1;
          why = $sformatf("byte %0d got %02h/sof%0b exp %02h/sof%0b",
                          i, rxData[i], rxSof[i], e[i], (i == 0));
        end
      end
    end
    if (bad) begin
      failures++;
      $display("FAIL %s len=%0d pad=%0b off=%0b add=%0b: %s",
               tag, d.size(), pe, fo, af, why);
    end
    got = rxData;
    rxData.delete(); rxSof.delete();
  endtask

  task automatic fillRand(ref logic [7:0] d[$], input int n);
    d.delete();
    for (int i = 0; i < n; i++) d.push_back(8'($urandom));
  endtask

  task automatic checkTrue(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    logic [7:0] got[$];
    logic [31:0] seed;
    seed = $urandom(32'h1357);
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    checkTrue("R10 outValid after reset", outValid == 1'b0, int'(outValid), 0);
    checkTrue("R10 inReady follows outReady", inReady == outReady, int'(inReady), int'(outReady));
    @(posedge clk); #1;

    // R3 known vector "123456789"
    d = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    runFrame("R3 R7 known vector", d, 0, 0, 1, got);
    checkTrue("R3 fcs bytes 26 39 F4 CB",
              got.size() == 13 && got[9] == 8'h26 && got[10] == 8'h39 &&
              got[11] == 8'hF4 && got[12] == 8'hCB, got.size(), 13);
    runFrame("R7 no request", d, 0, 0, 0, got);
    runFrame("R7 global disable", d, 0, 1, 1, got);

    // R2 R4 padding
    fillRand(d, 1);  runFrame("R2 R4 one byte forced fcs", d, 1, 1, 0, got);
    checkTrue("R2 R4 padded length", got.size() == 64, got.size(), 64);
    fillRand(d, 59); runFrame("R2 fifty-nine bytes", d, 1, 0, 0, got);
    fillRand(d, 60); runFrame("R6 sixty no fcs", d, 1, 0, 0, got);
    fillRand(d, 60); runFrame("R6 sixty with fcs", d, 1, 0, 1, got);
    checkTrue("R6 sixty with fcs length", got.size() == 64, got.size(), 64);
    fillRand(d, 10); runFrame("R5 pad disabled", d, 0, 0, 0, got);
    fillRand(d, 61); runFrame("R6 long padded off", d, 1, 1, 1, got);

    // R1 R2 R3 R5 R7 R8 R9 random mix with back-pressure and gaps
    randReady = 1; gapsOn = 1;
    for (int f = 0; f < 40; f++) begin
      int n;
      n = (f % 5 == 0) ? 55 + ($urandom % 10) : 1 + ($urandom % 90);
      fillRand(d, n);
      runFrame("R1 R2 R3 R5 R7 random", d, 1'($urandom), 1'($urandom), 1'($urandom), got);
    end
    fillRand(d, 3); runFrame("R8 R9 short padded stall", d, 1, 0, 0, got);
    randReady = 0; gapsOn = 0;
    repeat (4) @(posedge clk);

    checkTrue("R8 inReady low during tail", r8Viol == 0, r8Viol, 0);
    checkTrue("R9 output held under stall", r9Viol == 0, r9Viol, 0);
    checkTrue("R8 tail probes seen", tailReq == tailAck && tailReq > 0, tailAck, tailReq);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule